// File: doc/BRIEF.md
# Phase-Offset Synchronized Divider Bank

This block is a bank of clock dividers that all restart together when a synchronization event ends. It runs on one fast clock. Each fast-clock cycle stands for one half period of the source clock that the dividers divide. Each channel produces a registered output level. That level is high for `D` fast cycles and low for `D` fast cycles, which gives a divided clock of `D` source periods.

Each channel has a per-channel initial phase offset of 0 to 63 half periods. The offset delays only the first rising edge after a restart.

There are three restart sources:
- the PLL-ready flag: while it is low, every channel is held;
- an asynchronous sync pin, which passes through a synchronizer;
- a software sync bit.

The pin and the bit are ORed. While either one is high, every channel that is not set to ignore sync is held with its output low. The channels restart on the falling edge of the combined request. At that moment each held channel takes its divide and phase settings from its configuration inputs. Setting changes made while a channel runs stay invisible until its next restart.

Top module: `sync_divider_bank`

## Requirements
- R1: While `rst` is high and in the first cycle after it, every bit of `clk_out` is 0.
- R2: While `pll_ready` is low, all channels are held with output 0, including channels that ignore sync. When `pll_ready` is first seen high at clock edge A, a channel with phase offset P gives its first high output after edge A+PIPE_DEPTH+P.
- R3: Once running, a channel with divide value D is high for D cycles and then low for D cycles, repeating. A divide value of 0 behaves as 1.
- R4: The phase offset P (0..63) delays the first high output by exactly P cycles. Later periods are not affected.
- R5: Setting `sync_bit` alone does not restart a channel. When the bit is first seen low at edge A, the first high output comes after edge A+PIPE_DEPTH+P.
- R6: `sync_pin` passes through SYNC_STAGES flip-flops. When it is first seen low at edge A, the first high output comes after edge A+SYNC_STAGES+PIPE_DEPTH+P. When it is first seen high at edge A, non-ignoring outputs are 0 from edge A+SYNC_STAGES+PIPE_DEPTH on.
- R7: The pin and the bit are ORed. The hold lasts until both are low, and the restart timing follows whichever of the two falls last.
- R8: When `sync_bit` is first seen high at edge A, every non-ignoring output is 0 from edge A+PIPE_DEPTH until the restart. Before that edge, the outputs continue unchanged.
- R9: A channel whose `cfg_ignore` bit is 1 keeps its running waveform through a pin or bit sync. It also keeps its old settings through that sync.
- R10: Changes to `cfg_div` or `cfg_phase` while a channel runs leave its output unchanged until its next restart.
- R11: All restarted channels with equal settings produce identical outputs, cycle for cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast clock, one period per source half period |
| rst | input | 1 | synchronous active-high reset |
| sync_pin | input | 1 | asynchronous sync request, active high |
| sync_bit | input | 1 | software sync request, restart on clear |
| pll_ready | input | 1 | source ready; low holds every channel |
| cfg_div | input | N_CH*DIV_W | divide value per channel, channel n at bits n*DIV_W |
| cfg_phase | input | N_CH*PH_W | initial phase offset per channel, channel n at bits n*PH_W |
| cfg_ignore | input | N_CH | per-channel flag: 1 = unaffected by pin and bit sync |
| clk_out | output | N_CH | divided output level per channel |

## Verification
The bench checks the edge of the first rising output after each restart. It covers offsets 0 and 63 and a divide value of 0. A latency that is off by one stage, or an offset that is not applied, shows up as a high output one cycle early or late.

The bench also rewrites settings while channels run, and it sets the sync bit and holds it. A design that loads settings without waiting for a restart would bend the running waveform. So would one that restarts when the bit is set rather than when it is cleared.

Overlapping pin and bit requests check that the later release rules. An ignoring channel is also given a new setting during a pin sync, and its waveform must carry on untouched. A design that ORed the sources wrongly would restart too early, and one that honoured the ignore flag wrongly would blank that channel.

// File: rtl/sdb_pkg.sv
package sdb_pkg;

  // Hold request travelling down the release pipeline.
  // all : forces every channel (source not ready)
  // sel : pin or software sync, masked per channel by its ignore flag
  typedef struct packed {
    logic all;
    logic sel;
  } hold_t;

  localparam hold_t HOLD_AT_RESET = '{all: 1'b1, sel: 1'b0};

  typedef enum logic [1:0] {
    CH_HOLD  = 2'd0,
    CH_PHASE = 2'd1,
    CH_RUN   = 2'd2
  } ch_state_e;

endpackage

// File: rtl/sdb_sync_event.sv
module sdb_sync_event
  import sdb_pkg::*;
#(
  parameter int PIPE_DEPTH  = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  sync_pin,
  input  logic  sync_bit,
  input  logic  pll_ready,
  output hold_t hold
);

  logic [SYNC_STAGES-1:0] pin_meta;
  hold_t                  req;
  hold_t [PIPE_DEPTH-1:0] stage_q;

  // Bring the asynchronous pin into the clock domain.
  always_ff @(posedge clk) begin
    if (rst) pin_meta <= '0;
    else     pin_meta <= {pin_meta[SYNC_STAGES-2:0], sync_pin};
  end

  // Both sync sources are ORed; readiness is a separate, unmaskable request.
  always_comb begin
    req.all = ~pll_ready;
    req.sel = pin_meta[SYNC_STAGES-1] | sync_bit;
  end

  // Fixed-latency pipeline between request and channels.
  always_ff @(posedge clk) begin
    if (rst) stage_q <= {PIPE_DEPTH{HOLD_AT_RESET}};
    else     stage_q <= {stage_q[PIPE_DEPTH-2:0], req};
  end

  assign hold = stage_q[PIPE_DEPTH-1];

endmodule

// File: rtl/sdb_channel.sv
module sdb_channel
  import sdb_pkg::*;
#(
  parameter int DIV_W = 10,
  parameter int PH_W  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic [DIV_W-1:0] div_cfg,
  input  logic [PH_W-1:0]  phase_cfg,
  output logic             clk_en
);

  localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);
  localparam logic [PH_W-1:0]  PH_ONE  = PH_W'(1);

  ch_state_e        state;
  logic [DIV_W-1:0] div_act;
  logic [DIV_W-1:0] div_eff;
  logic [DIV_W-1:0] cnt;
  logic [PH_W-1:0]  dly;
  logic             half_done;

  assign div_eff   = (div_cfg == '0) ? DIV_ONE : div_cfg;
  assign half_done = (cnt == div_act - DIV_ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= CH_HOLD;
      div_act <= DIV_ONE;
      cnt     <= '0;
      dly     <= '0;
      clk_en  <= 1'b0;
    end else if (hold) begin
      // Shadow load: settings become active only across a restart.
      state   <= CH_HOLD;
      div_act <= div_eff;
      dly     <= phase_cfg;
      cnt     <= '0;
      clk_en  <= 1'b0;
    end else begin
      unique case (state)
        CH_HOLD, CH_PHASE: begin
          if (dly != '0) begin
            state <= CH_PHASE;
            dly   <= dly - PH_ONE;
          end else begin
            state  <= CH_RUN;
            cnt    <= '0;
            clk_en <= 1'b1;
          end
        end
        CH_RUN: begin
          if (half_done) begin
            cnt    <= '0;
            clk_en <= ~clk_en;
          end else begin
            cnt <= cnt + DIV_ONE;
          end
        end
        default: state <= CH_HOLD;
      endcase
    end
  end

endmodule

// File: rtl/sync_divider_bank.sv
module sync_divider_bank
  import sdb_pkg::*;
#(
  parameter int N_CH        = 4,
  parameter int DIV_W       = 10,
  parameter int PH_W        = 6,
  parameter int PIPE_DEPTH  = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sync_pin,
  input  logic                  sync_bit,
  input  logic                  pll_ready,
  input  logic [N_CH*DIV_W-1:0] cfg_div,
  input  logic [N_CH*PH_W-1:0]  cfg_phase,
  input  logic [N_CH-1:0]       cfg_ignore,
  output logic [N_CH-1:0]       clk_out
);

  hold_t hold;

  sdb_sync_event #(
    .PIPE_DEPTH (PIPE_DEPTH),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_evt (
    .clk      (clk),
    .rst      (rst),
    .sync_pin (sync_pin),
    .sync_bit (sync_bit),
    .pll_ready(pll_ready),
    .hold     (hold)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic ch_hold;
    assign ch_hold = hold.all | (hold.sel & ~cfg_ignore[g]);

    sdb_channel #(
      .DIV_W(DIV_W),
      .PH_W (PH_W)
    ) u_ch (
      .clk      (clk),
      .rst      (rst),
      .hold     (ch_hold),
      .div_cfg  (cfg_div[g*DIV_W +: DIV_W]),
      .phase_cfg(cfg_phase[g*PH_W +: PH_W]),
      .clk_en   (clk_out[g])
    );
  end

endmodule

// File: rtl/sdb_checker.sv
module sdb_checker #(
  parameter int N_CH        = 4,
  parameter int PIPE_DEPTH  = 11,
  parameter int SYNC_STAGES = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            sync_pin,
  input logic            sync_bit,
  input logic            pll_ready,
  input logic [N_CH-1:0] cfg_ignore,
  input logic [N_CH-1:0] clk_out
);

  localparam int LIM_REG = PIPE_DEPTH + 1;
  localparam int LIM_PIN = PIPE_DEPTH + SYNC_STAGES + 1;
  localparam int CW      = $clog2(LIM_PIN + 1) + 1;

  logic [CW-1:0] nr_cnt, bit_cnt, pin_cnt;

  // Saturating run-length counters of each request level.
  always_ff @(posedge clk) begin
    if (rst) begin
      nr_cnt  <= '0;
      bit_cnt <= '0;
      pin_cnt <= '0;
    end else begin
      nr_cnt  <= pll_ready  ? '0 : ((nr_cnt  < CW'(LIM_REG)) ? nr_cnt  + CW'(1) : nr_cnt);
      bit_cnt <= !sync_bit  ? '0 : ((bit_cnt < CW'(LIM_REG)) ? bit_cnt + CW'(1) : bit_cnt);
      pin_cnt <= !sync_pin  ? '0 : ((pin_cnt < CW'(LIM_PIN)) ? pin_cnt + CW'(1) : pin_cnt);
    end
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (clk_out == '0));

  assert_not_ready_blank_R2: assert property (@(posedge clk) disable iff (rst)
    (nr_cnt == CW'(LIM_REG)) |-> (clk_out == '0));

  assert_bit_blanks_R8: assert property (@(posedge clk) disable iff (rst)
    (bit_cnt == CW'(LIM_REG) && $stable(cfg_ignore)) |-> ((clk_out & ~cfg_ignore) == '0));

  assert_pin_blanks_R6: assert property (@(posedge clk) disable iff (rst)
    (pin_cnt == CW'(LIM_PIN) && $stable(cfg_ignore)) |-> ((clk_out & ~cfg_ignore) == '0));

endmodule

bind sync_divider_bank sdb_checker #(
  .N_CH       (N_CH),
  .PIPE_DEPTH (PIPE_DEPTH),
  .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sync_pin  (sync_pin),
  .sync_bit  (sync_bit),
  .pll_ready (pll_ready),
  .cfg_ignore(cfg_ignore),
  .clk_out   (clk_out)
);

// File: tb/tb_sync_divider_bank.sv
`timescale 1ns/1ps
module tb_sync_divider_bank;
  localparam int N_CH = 4, DIV_W = 10, PH_W = 6, PD = 11, SS = 2;
  localparam int WIN = PD + SS + 63 + 40;

  logic clk = 1'b0, rst = 1'b1;
  logic sync_pin = 1'b0, sync_bit = 1'b0, pll_ready = 1'b0;
  logic [N_CH*DIV_W-1:0] cfg_div = '0;
  logic [N_CH*PH_W-1:0]  cfg_phase = '0;
  logic [N_CH-1:0]       cfg_ignore = '0;
  logic [N_CH-1:0]       clk_out;

  sync_divider_bank #(.N_CH(N_CH), .DIV_W(DIV_W), .PH_W(PH_W),
    .PIPE_DEPTH(PD), .SYNC_STAGES(SS)) dut (.*);

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int cyc; int ch; bit val; string tag; } item_t;
  item_t exp_q[$];
  int n_chk = 0, n_fail = 0;
  int cd[N_CH], cp[N_CH], t_ref[N_CH], d_run[N_CH];
  bit ign[N_CH];

  task automatic do_check(string tag, int ch, bit act, bit expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s ch%0d cyc %0d: actual %0b expected %0b", tag, ch, cyc, act, expv);
    end
  endtask

  function automatic bit model_val(int ch, int t);
    if (t < t_ref[ch]) return 1'b0;
    return ((t - t_ref[ch]) % (2 * d_run[ch])) < d_run[ch];
  endfunction

  task automatic set_cfg(int ch, int d, int p, bit ig);
    cd[ch] = d; cp[ch] = p; ign[ch] = ig;
    cfg_div[ch*DIV_W +: DIV_W]  = DIV_W'(d);
    cfg_phase[ch*PH_W +: PH_W]  = PH_W'(p);
    cfg_ignore[ch]              = ig;
  endtask

  // Bench model of a restart seen first at the edge after cycle c0.
  task automatic arm(int c0, int extra, bit honour_ign);
    for (int ch = 0; ch < N_CH; ch++)
      if (!(honour_ign && ign[ch])) begin
        t_ref[ch] = c0 + 1 + PD + extra + cp[ch];
        d_run[ch] = (cd[ch] == 0) ? 1 : cd[ch];
      end
  endtask

  task automatic expect_span(int ch, int from, int to, string tag);
    for (int t = from; t <= to; t++) exp_q.push_back('{t, ch, model_val(ch, t), tag});
  endtask

  task automatic expect_zero(int ch, int from, int to, string tag);
    for (int t = from; t <= to; t++) exp_q.push_back('{t, ch, 1'b0, tag});
  endtask

  // Monitor: compare due items against the outputs between edges.
  always @(negedge clk) begin
    for (int i = exp_q.size() - 1; i >= 0; i--)
      if (exp_q[i].cyc == cyc) begin
        do_check(exp_q[i].tag, exp_q[i].ch, clk_out[exp_q[i].ch], exp_q[i].val);
        exp_q.delete(i);
      end
  end

  task automatic wait_until(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog: actual hung, expected completion");
    finish_run();
  end

  initial begin
    int c0, cs;
    for (int ch = 0; ch < N_CH; ch++) begin t_ref[ch] = 1 << 30; d_run[ch] = 1; end
    set_cfg(0, 3, 0, 0); set_cfg(1, 1, 63, 0); set_cfg(2, 5, 7, 0); set_cfg(3, 3, 0, 0);
    repeat (2) @(negedge clk);
    do_check("R1", 0, |clk_out, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    do_check("R1", 0, |clk_out, 1'b0);

    // R2/R3/R4/R11: start from readiness; ch1 offset 63, ch0 and ch3 identical
    repeat (5) @(negedge clk);
    c0 = cyc; pll_ready = 1'b1; arm(c0, 0, 0);
    expect_span(0, c0 + 1, c0 + WIN, "R3");
    expect_span(1, c0 + 1, c0 + WIN, "R4");
    expect_span(2, c0 + 1, c0 + WIN, "R2");
    expect_span(3, c0 + 1, c0 + WIN, "R11");
    wait_until(c0 + WIN + 1);

    // R10: new settings while running change nothing
    c0 = cyc;
    set_cfg(0, 2, 5, 0); set_cfg(1, 4, 0, 0); set_cfg(2, 1, 1, 0); set_cfg(3, 0, 2, 0);
    for (int ch = 0; ch < N_CH; ch++) expect_span(ch, c0 + 1, c0 + 40, "R10");
    wait_until(c0 + 40);

    // R5/R8: bit set blanks after the pipeline, restart on clear
    cs = cyc; sync_bit = 1'b1;
    for (int ch = 0; ch < N_CH; ch++) begin
      expect_span(ch, cs + 1, cs + PD, "R5");
      expect_zero(ch, cs + PD + 1, cs + 20 + PD, "R8");
    end
    repeat (20) @(negedge clk);
    c0 = cyc; sync_bit = 1'b0; arm(c0, 0, 0);
    for (int ch = 0; ch < N_CH; ch++) expect_span(ch, c0 + PD + 1, c0 + WIN, "R5");
    wait_until(c0 + WIN + 1);

    // R6/R9: pin sync, ch2 ignores it and gets a setting it must not adopt
    set_cfg(0, 4, 63, 0); set_cfg(1, 2, 1, 0); set_cfg(2, 7, 0, 1); set_cfg(3, 3, 10, 0);
    @(negedge clk);
    cs = cyc; sync_pin = 1'b1;
    for (int ch = 0; ch < N_CH; ch++)
      if (ch != 2) begin
        expect_span(ch, cs + 1, cs + SS + PD, "R6");
        expect_zero(ch, cs + SS + PD + 1, cs + 15 + SS + PD, "R6");
      end
    expect_span(2, cs + 1, cs + 15, "R9");
    repeat (15) @(negedge clk);
    c0 = cyc; sync_pin = 1'b0; arm(c0, SS, 1);
    for (int ch = 0; ch < N_CH; ch++)
      expect_span(ch, (ch == 2) ? c0 + 1 : c0 + SS + PD + 1, c0 + WIN, (ch == 2) ? "R9" : "R6");
    wait_until(c0 + WIN + 1);

    // R7: overlapping pin and bit; the later bit clear rules
    set_cfg(0, 2, 0, 0); set_cfg(1, 2, 0, 0); set_cfg(2, 7, 0, 0); set_cfg(3, 0, 63, 0);
    @(negedge clk);
    cs = cyc; sync_pin = 1'b1;
    for (int ch = 0; ch < N_CH; ch++) begin
      expect_span(ch, cs + 1, cs + SS + PD, "R7");
      expect_zero(ch, cs + SS + PD + 1, cs + 25 + PD, "R7");
    end
    repeat (3) @(negedge clk);
    sync_bit = 1'b1;
    repeat (7) @(negedge clk);
    sync_pin = 1'b0;
    repeat (15) @(negedge clk);
    c0 = cyc; sync_bit = 1'b0; arm(c0, 0, 0);
    for (int ch = 0; ch < N_CH; ch++) expect_span(ch, c0 + PD + 1, c0 + WIN, "R7");
    wait_until(c0 + WIN + 2);

    while (exp_q.size() != 0) @(negedge clk);
    finish_run();
  end
endmodule